// File: doc/BRIEF.md
# Three-Wire Codec Control Serializer

This block is a write-only master for the three-line control port of an audio codec. A host strobes in one control byte together with a one-bit mode select. The block then drives a bus clock, a bus data line and a bus mode line so that the codec can latch the byte one bit per rising clock edge. All bus timing is taken from a count of system clock cycles, so the host never toggles the lines itself.

A transfer runs in three steps. First, the mode line takes the requested level and holds it for a setup interval while the clock stays high and data stays low. Next come eight bit slots, sent least significant bit first. In each slot the clock is low for one half-period with the bit on the data line, then high for one half-period with data unchanged. Last, the lines go back to their rest pattern, and a one-cycle done pulse tells the host that it may start the next byte. The host frames multi-byte commands by sequencing single-byte transfers with the mode select.

Top module: `codec_ctl_ser`

## Requirements
- R1: Each transfer sends exactly 8 bits of the byte captured at acceptance, least significant bit first. Each bit is valid on `bus_dat_o` at the rising edge of `bus_clk_o`.
- R2: After reset and whenever `busy_o` is low, the bus rests at `bus_clk_o`=1, `bus_dat_o`=0, `bus_mode_o`=1.
- R3: On the clock edge that accepts a start, `bus_mode_o` takes the requested mode, and `bus_clk_o` stays 1 and `bus_dat_o` stays 0. This holds for exactly SETUP_CYC system cycles before the first falling edge of `bus_clk_o`. SETUP_CYC times the clock period is at least 190 ns (200 ns by default).
- R4: In every bit slot, `bus_clk_o` is low for HALF_CYC cycles with the bit on `bus_dat_o`, then high for HALF_CYC cycles with `bus_dat_o` unchanged. The default is 100 cycles, or 1 us at 100 MHz.
- R5: At the clock edge that ends the eighth high half, the bus returns to the rest pattern of R2, `busy_o` falls, and `done_o` is high for exactly that one cycle.
- R6: A start is accepted only at an edge where `busy_o` is low. A start seen while busy has no effect on the byte sent or on the length of the transfer.
- R7: The byte and the mode are captured at acceptance. Later changes on `byte_i` and `mode_i` do not affect the transfer in progress.
- R8: `busy_o` is high for exactly SETUP_CYC + 16*HALF_CYC cycles per transfer, starting the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to send one byte |
| byte_i | input | NBITS | Byte to send |
| mode_i | input | 1 | Level for the mode line during the transfer |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse at the end of a transfer |
| bus_clk_o | output | 1 | Bus clock, idles high |
| bus_dat_o | output | 1 | Bus data |
| bus_mode_o | output | 1 | Bus mode line, idles high |

## Verification
The bench sends the bytes 0xA5, 0x01, 0x80, 0xFF, 0x00 and 0x3C with both mode levels. A lone low or high bit at either end shows whether the bit order is reversed, and all-ones and all-zeros show a stuck data line or a lost edge. One transfer changes `byte_i` and `mode_i` partway through and also pulses `start_i` while busy. Another keeps `start_i` high through the done cycle, so the next transfer must start back to back with a fresh setup phase. A behavioural model predicts all five outputs on every cycle. Separate checks rebuild each byte from the rising bus clock edges and measure the mode setup time in nanoseconds.

// File: rtl/codec_ctl_pkg.sv
package codec_ctl_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_SETUP = 2'd1,
      PH_LOW   = 2'd2,
      PH_HIGH  = 2'd3
   } cctl_phase_t;

   function automatic int cctl_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/cctl_tick_timer.sv
module cctl_tick_timer #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          expired
);
   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);
endmodule

// File: rtl/cctl_bit_shifter.sv
module cctl_bit_shifter #(
   parameter int NBITS     = 8,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture,
   input  logic [NBITS-1:0] cap_byte,
   input  logic             advance,
   output logic             cur_bit,
   output logic             all_sent
);
   localparam int CW = $clog2(NBITS + 1);

   logic [NBITS-1:0] sr;
   logic [CW-1:0]    sent;

   generate
      if (LSB_FIRST) begin : g_lsb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       sr <= '0;
            else if (capture) sr <= cap_byte;
            else if (advance) sr <= {1'b0, sr[NBITS-1:1]};
         end
         assign cur_bit = sr[0];
      end else begin : g_msb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       sr <= '0;
            else if (capture) sr <= cap_byte;
            else if (advance) sr <= {sr[NBITS-2:0], 1'b0};
         end
         assign cur_bit = sr[NBITS-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sent <= '0;
      else if (capture) sent <= '0;
      else if (advance) sent <= sent + 1'b1;
   end

   assign all_sent = (sent == CW'(NBITS));
endmodule

// File: rtl/codec_ctl_ser.sv
module codec_ctl_ser
   import codec_ctl_pkg::*;
#(
   parameter int NBITS         = 8,
   parameter int HALF_CYC      = 100,
   parameter int SETUP_CYC     = 20,
   parameter int CLK_PERIOD_NS = 10,
   parameter int MIN_SETUP_NS  = 190,
   parameter bit LSB_FIRST     = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [NBITS-1:0] byte_i,
   input  logic             mode_i,
   output logic             busy_o,
   output logic             done_o,
   output logic             bus_clk_o,
   output logic             bus_dat_o,
   output logic             bus_mode_o
);
   localparam int MAXC = cctl_max(HALF_CYC, SETUP_CYC);
   localparam int TW   = $clog2(MAXC + 1);
   localparam logic [TW-1:0] SETUP_LD = TW'(SETUP_CYC - 1);
   localparam logic [TW-1:0] HALF_LD  = TW'(HALF_CYC - 1);

   initial begin
      assert (NBITS >= 2) else $error("NBITS must be at least 2");
      assert (HALF_CYC >= 1) else $error("HALF_CYC must be at least 1");
      assert (SETUP_CYC >= 1) else $error("SETUP_CYC must be at least 1");
      assert (SETUP_CYC * CLK_PERIOD_NS >= MIN_SETUP_NS)
         else $error("SETUP_CYC too short for the mode setup time");
   end

   cctl_phase_t   phase;
   logic          t_expired;
   logic          t_load;
   logic [TW-1:0] t_val;
   logic          accept;
   logic          shift_adv;
   logic          cur_bit;
   logic          all_sent;

   assign accept    = (phase == PH_IDLE) && start_i;
   assign shift_adv = (phase == PH_LOW) && t_expired;

   always_comb begin
      t_load = 1'b0;
      t_val  = HALF_LD;
      unique case (phase)
         PH_IDLE:  begin t_load = start_i; t_val = SETUP_LD; end
         PH_SETUP: t_load = t_expired;
         PH_LOW:   t_load = t_expired;
         PH_HIGH:  t_load = t_expired && !all_sent;
      endcase
   end

   cctl_tick_timer #(.TW(TW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .expired  (t_expired)
   );

   cctl_bit_shifter #(.NBITS(NBITS), .LSB_FIRST(LSB_FIRST)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .capture  (accept),
      .cap_byte (byte_i),
      .advance  (shift_adv),
      .cur_bit  (cur_bit),
      .all_sent (all_sent)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= PH_IDLE;
         busy_o     <= 1'b0;
         done_o     <= 1'b0;
         bus_clk_o  <= 1'b1;
         bus_dat_o  <= 1'b0;
         bus_mode_o <= 1'b1;
      end else begin
         done_o <= 1'b0;
         unique case (phase)
            PH_IDLE: if (start_i) begin
               phase      <= PH_SETUP;
               busy_o     <= 1'b1;
               bus_mode_o <= mode_i;
            end
            PH_SETUP: if (t_expired) begin
               phase     <= PH_LOW;
               bus_clk_o <= 1'b0;
               bus_dat_o <= cur_bit;
            end
            PH_LOW: if (t_expired) begin
               phase     <= PH_HIGH;
               bus_clk_o <= 1'b1;
            end
            PH_HIGH: if (t_expired) begin
               if (all_sent) begin
                  phase      <= PH_IDLE;
                  busy_o     <= 1'b0;
                  done_o     <= 1'b1;
                  bus_dat_o  <= 1'b0;
                  bus_mode_o <= 1'b1;
               end else begin
                  phase     <= PH_LOW;
                  bus_clk_o <= 1'b0;
                  bus_dat_o <= cur_bit;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/codec_ctl_ser_chk.sv
module codec_ctl_ser_chk #(
   parameter int SETUP_CYC = 20
) (
   input logic clk,
   input logic rst_n,
   input logic start_i,
   input logic busy_o,
   input logic done_o,
   input logic bus_clk_o,
   input logic bus_dat_o,
   input logic bus_mode_o
);
   localparam int SW = $clog2(SETUP_CYC + 2);

   logic [SW-1:0] setup_cnt;
   logic          seen_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         setup_cnt <= '0;
         seen_fall <= 1'b0;
      end else if (!busy_o) begin
         setup_cnt <= '0;
         seen_fall <= 1'b0;
      end else if (!bus_clk_o) begin
         seen_fall <= 1'b1;
      end else if (!seen_fall) begin
         setup_cnt <= setup_cnt + 1'b1;
      end
   end

   AST_REST_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (bus_clk_o && !bus_dat_o && bus_mode_o)); // R2

   AST_SETUP_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !bus_clk_o && !seen_fall) |-> (setup_cnt == SW'(SETUP_CYC))); // R3

   AST_DATA_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && bus_clk_o && $past(bus_clk_o)) |-> $stable(bus_dat_o)); // R4

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R5

   AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o))); // R5

   AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o); // R6

   AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(bus_mode_o)); // R7
endmodule

bind codec_ctl_ser codec_ctl_ser_chk #(.SETUP_CYC(SETUP_CYC)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .bus_clk_o  (bus_clk_o),
   .bus_dat_o  (bus_dat_o),
   .bus_mode_o (bus_mode_o)
);

// File: tb/tb_codec_ctl_ser.sv
`timescale 1ns/1ps
module tb_codec_ctl_ser;
   localparam int S   = 20;
   localparam int H   = 100;
   localparam int TOT = S + 16 * H;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [7:0] byte_i = 8'h00;
   logic       mode_i = 1'b0;
   logic       busy_o, done_o, bus_clk_o, bus_dat_o, bus_mode_o;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   codec_ctl_ser #(.NBITS(8), .HALF_CYC(H), .SETUP_CYC(S)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_i(byte_i),
      .mode_i(mode_i), .busy_o(busy_o), .done_o(done_o),
      .bus_clk_o(bus_clk_o), .bus_dat_o(bus_dat_o), .bus_mode_o(bus_mode_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // Behavioural reference model
   bit         m_active = 0;
   int         m_t = 0;
   logic [7:0] m_d = 8'h00;
   logic       m_m = 1'b1;
   bit         m_done = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_active = 0; m_t = 0; m_done = 0;
      end else begin
         m_done = 0;
         if (m_active) begin
            if (m_t == TOT - 1) begin
               m_active = 0;
               m_done = 1;
            end else m_t++;
         end else if (start_i) begin
            m_active = 1; m_t = 0; m_d = byte_i; m_m = mode_i;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         logic e_clk, e_dat, e_mode;
         if (!m_active) begin
            e_clk = 1; e_dat = 0; e_mode = 1;
         end else if (m_t < S) begin
            e_clk = 1; e_dat = 0; e_mode = m_m;
         end else begin
            int k;
            k = m_t - S;
            e_clk = ((k % (2 * H)) >= H);
            e_dat = m_d[k / (2 * H)];
            e_mode = m_m;
         end
         check(busy_o === m_active, "R8 busy vs model", int'(busy_o), int'(m_active));
         check(done_o === m_done, "R5 done vs model", int'(done_o), int'(m_done));
         check(bus_clk_o === e_clk, "R4 bus clock vs model", int'(bus_clk_o), int'(e_clk));
         check(bus_dat_o === e_dat, "R1 bus data vs model", int'(bus_dat_o), int'(e_dat));
         check(bus_mode_o === e_mode, "R3 bus mode vs model", int'(bus_mode_o), int'(e_mode));
      end
   end

   // Bus-level observers
   logic [7:0] rx = 8'h00;
   int         nrx = 0;
   time        t_busy = 0;
   time        setup_ns = 0;
   bit         first_fall = 0;
   logic       mode_at_fall = 1'b1;
   int         busy_cnt = 0;
   logic       prev_busy = 1'b0;

   always @(posedge busy_o) begin
      nrx = 0; rx = 8'h00; t_busy = $time; first_fall = 1;
   end

   always @(posedge bus_clk_o) begin
      if (busy_o === 1'b1) begin
         rx = {bus_dat_o, rx[7:1]};
         nrx++;
      end
   end

   always @(negedge bus_clk_o) begin
      if (busy_o === 1'b1 && first_fall) begin
         setup_ns = $time - t_busy;
         mode_at_fall = bus_mode_o;
         first_fall = 0;
      end
   end

   always @(negedge clk) begin
      if (busy_o === 1'b1 && prev_busy !== 1'b1) busy_cnt = 1;
      else if (busy_o === 1'b1) busy_cnt++;
      prev_busy = busy_o;
   end

   task automatic wait_done();
      do @(negedge clk); while (done_o !== 1'b1);
   endtask

   task automatic end_checks(input logic [7:0] b, input logic m);
      check(rx == b, "R1 byte rebuilt LSB first", int'(rx), int'(b));
      check(nrx == 8, "R1 rising edge count", nrx, 8);
      check(setup_ns >= 190, "R3 mode setup ns", int'(setup_ns), 190);
      check(setup_ns == S * 10, "R3 setup length ns", int'(setup_ns), S * 10);
      check(mode_at_fall == m, "R3 mode level at first fall", int'(mode_at_fall), int'(m));
      check(bus_clk_o && !bus_dat_o && bus_mode_o && !busy_o,
            "R5 rest pattern after transfer",
            int'({bus_clk_o, bus_dat_o, bus_mode_o}), 5);
      check(busy_cnt == TOT, "R8 busy cycle count", busy_cnt, TOT);
   endtask

   task automatic send(input logic [7:0] b, input logic m);
      @(negedge clk);
      start_i = 1'b1; byte_i = b; mode_i = m;
      @(negedge clk);
      start_i = 1'b0;
      wait_done();
      end_checks(b, m);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, TOT);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(bus_clk_o && !bus_dat_o && bus_mode_o && !busy_o && !done_o,
            "R2 reset state", int'({bus_clk_o, bus_dat_o, bus_mode_o}), 5);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check(bus_clk_o && !bus_dat_o && bus_mode_o && !busy_o,
            "R2 idle state", int'({bus_clk_o, bus_dat_o, bus_mode_o}), 5);

      send(8'hA5, 1'b0);
      send(8'h01, 1'b1);
      send(8'h80, 1'b0);
      send(8'hFF, 1'b1);
      send(8'h00, 1'b0);

      // R7 and R6: inputs change and start pulses while busy
      @(negedge clk);
      start_i = 1'b1; byte_i = 8'h3C; mode_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (300) @(negedge clk);
      byte_i = 8'hC3; mode_i = 1'b0; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (200) @(negedge clk);
      check(bus_mode_o == 1'b1, "R7 mode kept after mode_i change", int'(bus_mode_o), 1);
      wait_done();
      end_checks(8'h3C, 1'b1);
      @(negedge clk);
      check(!busy_o, "R6 start while busy ignored", int'(busy_o), 0);

      // R6: start held through done gives a back-to-back transfer
      @(negedge clk);
      start_i = 1'b1; byte_i = 8'h96; mode_i = 1'b0;
      wait_done();
      end_checks(8'h96, 1'b0);
      byte_i = 8'h5A; mode_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check(busy_o === 1'b1, "R6 back-to-back accept", int'(busy_o), 1);
      wait_done();
      end_checks(8'h5A, 1'b1);
      repeat (5) @(negedge clk);
      check(bus_clk_o && !bus_dat_o && bus_mode_o && !busy_o,
            "R2 final idle", int'({bus_clk_o, bus_dat_o, bus_mode_o}), 5);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule